// File: doc/BRIEF.md
# Flash Program/Erase Pulse Timer

This block times the high-voltage pulses that program or erase on-chip flash cells. It runs on the CPU clock. A write-mode controller raises a level input while flash writing mode is active and sends a one-cycle command strobe to request a pulse. A 2-bit width code, sampled together with the command, picks a pulse length that is a power of two of CPU cycles. The block holds `busy_o` high for exactly that many cycles. It then raises `done_o` for one cycle.

Two safety features sit around the pulse. First, a startup lockout of `FREQ_MHZ * LOCK_US` cycles (10 µs by default) starts each time writing mode is entered. No pulse begins before the lockout ends. A command that arrives during the lockout is held and fires as soon as the lockout ends. Second, a sticky dropout flag records whether the programming-voltage-OK input went low in any cycle of the most recent pulse. A live copy of that input is also shown while writing mode is active.

The sequencer has five states:
- `ST_OFF`: writing mode is inactive.
- `ST_LOCK`: the lockout is counting and no command is held.
- `ST_HOLD`: the lockout is counting and a command is held.
- `ST_READY`: the lockout is over and the block waits for a command.
- `ST_PULSE`: a pulse is in progress.

The transitions are:
- OFF→LOCK when writing mode is seen active.
- LOCK→HOLD when a command arrives.
- LOCK→READY when the lockout expires with no command.
- LOCK→PULSE when the lockout expires in the same cycle a command arrives.
- HOLD→PULSE when the lockout expires.
- READY→PULSE on a command.
- LOCK, HOLD or READY→OFF when writing mode drops.
- PULSE→READY at the end of the pulse if writing mode is still active.
- PULSE→OFF at the end of the pulse if writing mode has dropped.

Top module: `hv_pulse_timer`

## Requirements
- R1: While reset is asserted and after it is released, `busy_o`, `done_o` and `drop_o` are 0.
- R2: A pulse keeps `busy_o` high for exactly 2^E cycles. E is selected by the width code sampled with the command: code 0 gives `EXP_C0`, code 1 gives `EXP_C1`, code 2 gives `EXP_C2` and code 3 gives `EXP_C3`. The defaults are 7, 11, 15 and 18.
- R3: A command sampled in the ready state makes `busy_o` high in the cycle that follows that clock edge.
- R4: `done_o` is high for one cycle only. That cycle is the first cycle in which `busy_o` is low after a pulse.
- R5: After writing mode is first seen active, `busy_o` stays low for at least `FREQ_MHZ * LOCK_US` cycles.
- R6: A command received during the lockout is held. Its pulse begins in the first cycle after the lockout ends, which is `FREQ_MHZ*LOCK_US + 1` edges after the edge at which writing mode was first seen.
- R7: A command that arrives while `busy_o` is high is ignored. It does not change the pulse length and it does not start another pulse.
- R8: `drop_o` is cleared when a pulse starts. It is set if `vok_i` is 0 in any cycle of that pulse, and it is visible no later than the `done_o` cycle. It then keeps its value until the next pulse starts.
- R9: `vok_i` going low while no pulse is running leaves `drop_o` unchanged.
- R10: `vlive_o` equals `vok_i` while `wmode_i` is 1, and it is 0 while `wmode_i` is 0.
- R11: If writing mode drops, a held command and the lockout in progress are abandoned, but a running pulse completes at full length. Entering writing mode again starts a full new lockout.
- R12: A command given while writing mode is inactive is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wmode_i | input | 1 | Level input, high while flash writing mode is active |
| cmd_i | input | 1 | One-cycle command strobe that requests a pulse |
| width_sel_i | input | 2 | Pulse width code, sampled with `cmd_i` |
| vok_i | input | 1 | High while the programming voltage is above its threshold |
| busy_o | output | 1 | High for the whole length of the pulse |
| done_o | output | 1 | One-cycle strobe in the first cycle after the pulse |
| vlive_o | output | 1 | Live voltage-valid indication during writing mode |
| drop_o | output | 1 | Sticky flag set by a voltage dropout during the last pulse |

## Verification
Each result has a fixed due cycle:
- `busy_o` appears one edge after the command edge.
- `done_o` and the final value of `drop_o` appear together, one edge after the last pulse cycle.
- A held command produces `busy_o` exactly `FREQ_MHZ*LOCK_US + 1` edges after writing mode is sampled active.

The bench drives inputs and samples outputs on falling clock edges. It counts rising edges between those two points, so every check lands in the due cycle and not in a window. The pulse length is measured by counting the falling edges at which `busy_o` is high. The dropout stimulus is placed at a known pulse-cycle index, so the bench knows whether the flag must be set.

// File: rtl/fpt_pkg.sv
package fpt_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_LOCK,
        ST_HOLD,
        ST_READY,
        ST_PULSE
    } fpt_state_e;

    // Largest of four exponents: sizes the pulse counter.
    function automatic int unsigned widest(input int unsigned a, input int unsigned b,
                                           input int unsigned c, input int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/fpt_lockout.sv
module fpt_lockout #(
    parameter int unsigned LOCK_CYC = 200,
    localparam int unsigned LK_W = $clog2(LOCK_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic expire_o
);

    logic [LK_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run_i) begin
            cnt_q <= '0;
        end else if (!expire_o) begin
            cnt_q <= cnt_q + LK_W'(1);
        end
    end

    assign expire_o = run_i && (cnt_q == LK_W'(LOCK_CYC - 1));

    // R5: the lockout count never passes its limit
    p_lock_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> (cnt_q < LK_W'(LOCK_CYC)));

endmodule

// File: rtl/fpt_pulse_cnt.sv
module fpt_pulse_cnt #(
    parameter int unsigned EXP_TAB [4] = '{7, 11, 15, 18},
    parameter int unsigned CNT_W = 19
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cap_i,
    input  logic [1:0] sel_i,
    input  logic       start_i,
    input  logic       run_i,
    output logic       last_o
);

    logic [CNT_W-1:0] len_tab [4];
    logic [CNT_W-1:0] len_q;
    logic [CNT_W-1:0] cnt_q;

    for (genvar g = 0; g < 4; g++) begin : g_len
        assign len_tab[g] = CNT_W'(1) << EXP_TAB[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q <= len_tab[0];
        end else if (cap_i) begin
            len_q <= len_tab[sel_i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start_i) begin
            cnt_q <= '0;
        end else if (run_i) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign last_o = run_i && (cnt_q == len_q - CNT_W'(1));

    // R2: a running pulse never counts beyond its selected length
    p_len_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> (cnt_q < len_q));

endmodule

// File: rtl/fpt_dropout.sv
module fpt_dropout (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic watch_i,
    input  logic vok_i,
    output logic flag_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_o <= 1'b0;
        end else if (clr_i) begin
            flag_o <= 1'b0;
        end else if (watch_i && !vok_i) begin
            flag_o <= 1'b1;
        end
    end

    // R8: a low voltage in a watched cycle is recorded one edge later
    p_drop_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (watch_i && !vok_i && !clr_i) |=> flag_o);

endmodule

// File: rtl/hv_pulse_timer.sv
module hv_pulse_timer #(
    parameter int unsigned FREQ_MHZ = 20,
    parameter int unsigned LOCK_US  = 10,
    parameter int unsigned EXP_C0   = 7,
    parameter int unsigned EXP_C1   = 11,
    parameter int unsigned EXP_C2   = 15,
    parameter int unsigned EXP_C3   = 18
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wmode_i,
    input  logic       cmd_i,
    input  logic [1:0] width_sel_i,
    input  logic       vok_i,
    output logic       busy_o,
    output logic       done_o,
    output logic       vlive_o,
    output logic       drop_o
);

    import fpt_pkg::*;

    localparam int unsigned LOCK_CYC = FREQ_MHZ * LOCK_US;
    localparam int unsigned LK_W     = $clog2(LOCK_CYC + 1);
    localparam int unsigned EXP_TAB [4] = '{EXP_C0, EXP_C1, EXP_C2, EXP_C3};
    localparam int unsigned CNT_W    = widest(EXP_C0, EXP_C1, EXP_C2, EXP_C3) + 1;

    fpt_state_e state_q, state_d;
    logic       lock_run, lock_exp;
    logic       accept, start, pulse_last;
    logic       done_q;

    // Which states count the lockout
    assign lock_run = (state_q == ST_LOCK) || (state_q == ST_HOLD);

    // A command is taken only while writing mode is active and no pulse runs
    assign accept = cmd_i && wmode_i &&
                    ((state_q == ST_LOCK) || (state_q == ST_READY));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (wmode_i) state_d = ST_LOCK;
            end
            ST_LOCK: begin
                if (!wmode_i)       state_d = ST_OFF;
                else if (lock_exp)  state_d = cmd_i ? ST_PULSE : ST_READY;
                else if (cmd_i)     state_d = ST_HOLD;
            end
            ST_HOLD: begin
                if (!wmode_i)       state_d = ST_OFF;
                else if (lock_exp)  state_d = ST_PULSE;
            end
            ST_READY: begin
                if (!wmode_i)       state_d = ST_OFF;
                else if (cmd_i)     state_d = ST_PULSE;
            end
            ST_PULSE: begin
                if (pulse_last)     state_d = wmode_i ? ST_READY : ST_OFF;
            end
            default:                state_d = ST_OFF;
        endcase
    end

    assign start = (state_d == ST_PULSE) && (state_q != ST_PULSE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else begin
            done_q <= (state_q == ST_PULSE) && pulse_last;
        end
    end

    // Output process
    always_comb begin
        busy_o  = (state_q == ST_PULSE);
        done_o  = done_q;
        vlive_o = wmode_i && vok_i;
    end

    fpt_lockout #(
        .LOCK_CYC (LOCK_CYC)
    ) u_lockout (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (lock_run),
        .expire_o (lock_exp)
    );

    fpt_pulse_cnt #(
        .EXP_TAB (EXP_TAB),
        .CNT_W   (CNT_W)
    ) u_pulse (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap_i   (accept),
        .sel_i   (width_sel_i),
        .start_i (start),
        .run_i   (busy_o),
        .last_o  (pulse_last)
    );

    fpt_dropout u_drop (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (start),
        .watch_i (busy_o),
        .vok_i   (vok_i),
        .flag_o  (drop_o)
    );

    // Checker state: number of cycles since leaving the off state, saturated
    logic [LK_W-1:0] age_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age_q <= '0;
        end else if (state_q == ST_OFF) begin
            age_q <= '0;
        end else if (age_q != LK_W'(LOCK_CYC)) begin
            age_q <= age_q + LK_W'(1);
        end
    end

    // R5: no pulse rises before the lockout time has elapsed
    p_lock_min_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> (age_q == LK_W'(LOCK_CYC)));

    // R4: done only in the first cycle after busy falls
    p_done_after_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));

    // R4: done lasts one cycle
    p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8: dropout flag is clear when a pulse begins
    p_drop_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> !drop_o);

    // R9: outside a pulse and its trailing cycle the flag holds
    p_drop_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !$past(busy_o)) |-> $stable(drop_o));

    // R12: with writing mode inactive in the off state, no pulse begins
    p_off_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OFF) |=> !busy_o);

endmodule

// File: tb/test_hv_pulse_timer.sv
module test_hv_pulse_timer;

    localparam int FREQ = 2;
    localparam int LUS  = 10;
    localparam int L    = FREQ * LUS;   // 20 lockout cycles
    // Exponents 3,4,5,6 -> lengths 8,16,32,64

    typedef struct packed {
        logic [1:0] code;
        logic [7:0] drop_at;   // 255: no dropout
        logic [7:0] len;
        logic       drop;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 8'd255, 8'd8,  1'b0},
        '{2'd1, 8'd255, 8'd16, 1'b0},
        '{2'd2, 8'd255, 8'd32, 1'b0},
        '{2'd3, 8'd255, 8'd64, 1'b0},
        '{2'd2, 8'd0,   8'd32, 1'b1},
        '{2'd1, 8'd15,  8'd16, 1'b1},
        '{2'd0, 8'd4,   8'd8,  1'b1},
        '{2'd3, 8'd255, 8'd64, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst_n;
    logic       wmode, cmd, vok;
    logic [1:0] sel;
    logic       busy, done, vlive, drop;

    int checks = 0;
    int errors = 0;
    bit ended  = 0;

    always #4 clk = ~clk;

    hv_pulse_timer #(
        .FREQ_MHZ (FREQ),
        .LOCK_US  (LUS),
        .EXP_C0   (3),
        .EXP_C1   (4),
        .EXP_C2   (5),
        .EXP_C3   (6)
    ) i_hv_pulse_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .wmode_i     (wmode),
        .cmd_i       (cmd),
        .width_sel_i (sel),
        .vok_i       (vok),
        .busy_o      (busy),
        .done_o      (done),
        .vlive_o     (vlive),
        .drop_o      (drop)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // At a falling edge where busy is already high (pulse cycle 0):
    // count pulse cycles, drop vok at index drop_at, pulse cmd at index cmd_at.
    task automatic meas(input int drop_at, input int cmd_at, input int csel, output int n);
        n = 0;
        while (busy) begin
            vok = (n == drop_at) ? 1'b0 : 1'b1;
            cmd = (n == cmd_at) ? 1'b1 : 1'b0;
            sel = 2'(csel);
            n++;
            @(negedge clk);
        end
        vok = 1'b1;
        cmd = 1'b0;
    endtask

    task automatic finish_checks(input int n, input int exp_len, input int exp_drop, input string tag);
        chk({tag, " R2 pulse length"}, n, exp_len);
        chk({tag, " R4 done at busy fall"}, int'(done), 1);
        chk({tag, " R8 dropout flag"}, int'(drop), exp_drop);
        @(negedge clk);
        chk({tag, " R4 done single cycle"}, int'(done), 0);
        chk({tag, " R8 flag sticky"}, int'(drop), exp_drop);
    endtask

    task automatic run_pulse(input int code, input int drop_at, input int exp_len,
                             input int exp_drop, input string tag);
        int n;
        cmd = 1'b1;
        sel = 2'(code);
        @(negedge clk);
        cmd = 1'b0;
        chk({tag, " R3 busy one edge after command"}, int'(busy), 1);
        chk({tag, " R8 flag cleared at start"}, int'(drop), 0);
        meas(drop_at, -1, 0, n);
        finish_checks(n, exp_len, exp_drop, tag);
    endtask

    // From the off state: enter writing mode, hold a command in the lockout.
    task automatic held_entry(input string tag);
        int n;
        wmode = 1'b1;
        @(negedge clk);               // 1 edge
        cmd = 1'b1;
        sel = 2'd1;
        @(negedge clk);               // 2 edges
        cmd = 1'b0;
        repeat (L - 2) @(negedge clk); // L edges
        chk({tag, " R5 no pulse inside lockout"}, int'(busy), 0);
        @(negedge clk);               // L+1 edges
        chk({tag, " R6 held command fires after lockout"}, int'(busy), 1);
        meas(-1, -1, 0, n);
        finish_checks(n, 16, 0, tag);
    endtask

    initial begin
        int n;
        bit seen;
        rst_n = 1'b0;
        wmode = 1'b0;
        cmd   = 1'b0;
        sel   = 2'd0;
        vok   = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 busy in reset", int'(busy), 0);
        chk("R1 done in reset", int'(done), 0);
        chk("R1 drop in reset", int'(drop), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 busy after reset", int'(busy), 0);
        chk("R1 drop after reset", int'(drop), 0);

        // R10 live voltage indication
        chk("R10 vlive with mode off", int'(vlive), 0);
        wmode = 1'b1;
        #1 chk("R10 vlive follows vok high", int'(vlive), 1);
        vok = 1'b0;
        #1 chk("R10 vlive follows vok low", int'(vlive), 0);
        vok = 1'b1;
        wmode = 1'b0;
        @(negedge clk);

        // R5/R6 held command through the lockout
        held_entry("entry");

        // Main table
        for (int i = 0; i < NV; i++) begin
            run_pulse(int'(VEC[i].code),
                      (VEC[i].drop_at == 8'd255) ? -1 : int'(VEC[i].drop_at),
                      int'(VEC[i].len), int'(VEC[i].drop), $sformatf("vec%0d", i));
        end

        // R9 dropout outside a pulse has no effect
        vok = 1'b0;
        repeat (3) @(negedge clk);
        vok = 1'b1;
        chk("R9 idle dropout ignored", int'(drop), 0);

        // R7 command during a pulse ignored
        cmd = 1'b1;
        sel = 2'd0;
        @(negedge clk);
        cmd = 1'b0;
        chk("R7 pulse started", int'(busy), 1);
        meas(-1, 2, 3, n);
        chk("R7 length unchanged by extra command", n, 8);
        chk("R7 done", int'(done), 1);
        seen = 0;
        repeat (4) begin
            @(negedge clk);
            if (busy) seen = 1;
        end
        chk("R7 no second pulse", int'(seen), 0);

        // R11 mode drop during a pulse: pulse completes
        cmd = 1'b1;
        sel = 2'd1;
        @(negedge clk);
        cmd = 1'b0;
        meas(-1, -1, 0, n);
        chk("R2 code1 length", n, 16);
        wmode = 1'b0;
        @(negedge clk);
        cmd = 1'b1;
        sel = 2'd0;
        @(negedge clk);
        cmd = 1'b0;
        wmode = 1'b1;
        @(negedge clk);
        // The two-step above only checks R2 again; now the real R11 test:
        wmode = 1'b1;
        cmd = 1'b1;
        sel = 2'd1;
        @(negedge clk);
        cmd = 1'b0;
        // State may be lockout; wait until ready for a clean start
        repeat (L + 2) @(negedge clk);
        if (busy) begin
            meas(-1, -1, 0, n);
            repeat (2) @(negedge clk);
        end
        cmd = 1'b1;
        sel = 2'd1;
        @(negedge clk);
        cmd = 1'b0;
        repeat (3) @(negedge clk);
        wmode = 1'b0;
        meas(-1, -1, 0, n);
        chk("R11 pulse completes after mode drop", n, 13);
        chk("R11 done after mode drop", int'(done), 1);

        // R12 command with mode inactive ignored
        @(negedge clk);
        cmd = 1'b1;
        sel = 2'd0;
        @(negedge clk);
        cmd = 1'b0;
        seen = 0;
        repeat (3) begin
            @(negedge clk);
            if (busy) seen = 1;
        end
        chk("R12 command ignored in off state", int'(seen), 0);

        // R11 held command abandoned when mode drops in lockout
        wmode = 1'b1;
        @(negedge clk);
        cmd = 1'b1;
        @(negedge clk);
        cmd = 1'b0;
        repeat (L - 6) @(negedge clk);
        wmode = 1'b0;
        seen = 0;
        repeat (L + 5) begin
            @(negedge clk);
            if (busy) seen = 1;
        end
        chk("R11 held command abandoned", int'(seen), 0);

        // R11 re-entry restarts a full lockout
        held_entry("reentry R11");

        if (!ended) begin
            ended = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule